// File: doc/BRIEF.md
# Triggered Serial Remote-Control Encoder

This block turns a twelve-bit address/data code into a pulse-width-coded serial stream for a radio transmitter stage. It runs from the system clock and advances by one time slot on each cycle where a slot-rate clock-enable pulse is high. Transmission is requested by pulling an active-low enable. Each request produces a burst of four complete words. Every word opens with a long low pilot period, then a single high sync slot, then the twelve coded bits.

The enable is examined only while the block is idle and at the slot that closes a burst. A short trigger therefore always yields a full four-word burst. An enable held low yields further bursts back to back. The code inputs are captured at the first slot of every word. A change to the inputs while a word is being sent reaches the line only in the next word. When no burst is running, the output rests low and a standby flag is raised.

Top module: `rc_word_encoder`

## Requirements
- R1: During and right after reset, `ser_out` is 0 and `standby` is 1.
- R2: While `tx_en_n` is 1, an idle block stays idle on every slot tick: `standby` stays 1 and `ser_out` stays 0.
- R3: A burst starts only on a slot tick that finds `tx_en_n` at 0 while idle. The slot entered on that tick is pilot slot 0. An enable held low with no tick leaves the block in standby.
- R4: Once started, a burst always sends exactly four words (4 x 73 = 292 slots), even if `tx_en_n` returns to 1 right after the start tick.
- R5: At the tick that ends the last slot of a burst, `tx_en_n` at 0 starts a new burst with no gap. `tx_en_n` at 1 returns the block to standby on that tick.
- R6: A word is 36 slots low (pilot), then 1 slot high (sync), then 12 bits of 3 slots each: 73 slots in all.
- R7: A bit of value 1 is sent as high, low, low. A bit of value 0 is sent as high, high, low.
- R8: The bits go out in index order, `code_in[0]` first and `code_in[11]` last.
- R9: `code_in` is captured on the tick that enters pilot slot 0 of each word. A change made later in that word affects only later words.
- R10: State and `ser_out` change only on clock edges where `slot_tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_tick | input | 1 | One-cycle enable at the slot rate |
| tx_en_n | input | 1 | Transmit request, active low |
| code_in | input | 12 | Address/data bits, index 0 sent first |
| ser_out | output | 1 | Pulse-width-coded serial line |
| standby | output | 1 | High while no burst is running |

## Verification
Several codes are used: an asymmetric mixed pattern, all zeros, all ones, and single set bits at index 0 and at index 11. Together they separate the two bit shapes and expose a reversed bit order. Enable release points fall just after the start tick, inside the first burst, exactly on the first burst boundary, one slot past it, and deep in the third burst. These pin down the four-word minimum and the boundary sampling of the enable. A further case changes the code in the middle of a word to show the per-word capture. The slot-by-slot decoded stream is compared with one rebuilt from the requirements.

// File: rtl/rc_enc_pkg.sv
package rc_enc_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_PILOT = 2'd1,
    PH_SYNC  = 2'd2,
    PH_DATA  = 2'd3
  } enc_phase_e;

  // Level of one slot inside a coded bit: slot 0 always high,
  // slot 1 high only for a zero, last slot low.
  function automatic logic slot_level(input logic bit_val, input int unsigned sub);
    return (sub == 0) || ((sub == 1) && !bit_val);
  endfunction

  // Length of one word in slots.
  function automatic int unsigned word_slots(input int unsigned pilot,
                                             input int unsigned nbits,
                                             input int unsigned spb);
    return pilot + 1 + nbits * spb;
  endfunction

endpackage

// File: rtl/rc_enc_seq.sv
module rc_enc_seq
  import rc_enc_pkg::*;
#(
  parameter int unsigned NBITS  = 12,
  parameter int unsigned PILOT  = 36,
  parameter int unsigned SPB    = 3,
  parameter int unsigned WORDS  = 4,
  localparam int unsigned PW    = (PILOT > 1) ? $clog2(PILOT) : 1,
  localparam int unsigned BW    = (NBITS > 1) ? $clog2(NBITS) : 1,
  localparam int unsigned SW    = (SPB > 1) ? $clog2(SPB) : 1,
  localparam int unsigned WW    = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slot_tick,
  input  logic          tx_en_n,
  output enc_phase_e    phase,
  output logic [BW-1:0] bit_idx,
  output logic [SW-1:0] sub_idx,
  output logic          word_start
);

  localparam logic [PW-1:0] PIL_LAST  = PW'(PILOT - 1);
  localparam logic [BW-1:0] BIT_LAST  = BW'(NBITS - 1);
  localparam logic [SW-1:0] SUB_LAST  = SW'(SPB - 1);
  localparam logic [WW-1:0] WORD_LAST = WW'(WORDS - 1);

  enc_phase_e    phase_q;
  logic [PW-1:0] pil_q;
  logic [BW-1:0] bit_q;
  logic [SW-1:0] sub_q;
  logic [WW-1:0] word_q;

  // Named events for assertions and for the capture register
  logic start_idle, word_end, burst_end, pilot_done;
  assign pilot_done = (pil_q == PIL_LAST);
  assign word_end   = slot_tick && (phase_q == PH_DATA) &&
                      (sub_q == SUB_LAST) && (bit_q == BIT_LAST);
  assign burst_end  = word_end && (word_q == WORD_LAST);
  assign start_idle = slot_tick && (phase_q == PH_IDLE) && !tx_en_n;
  assign word_start = start_idle || (word_end && !burst_end) ||
                      (burst_end && !tx_en_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      pil_q   <= '0;
      bit_q   <= '0;
      sub_q   <= '0;
      word_q  <= '0;
    end else if (slot_tick) begin
      case (phase_q)
        PH_IDLE: begin
          if (!tx_en_n) begin
            phase_q <= PH_PILOT;
            pil_q   <= '0;
            word_q  <= '0;
          end
        end
        PH_PILOT: begin
          if (pilot_done) phase_q <= PH_SYNC;
          else            pil_q   <= pil_q + 1'b1;
        end
        PH_SYNC: begin
          phase_q <= PH_DATA;
          bit_q   <= '0;
          sub_q   <= '0;
        end
        default: begin
          if (sub_q == SUB_LAST) begin
            sub_q <= '0;
            if (bit_q == BIT_LAST) begin
              pil_q <= '0;
              if (word_q == WORD_LAST) begin
                word_q  <= '0;
                phase_q <= tx_en_n ? PH_IDLE : PH_PILOT;
              end else begin
                word_q  <= word_q + 1'b1;
                phase_q <= PH_PILOT;
              end
            end else begin
              bit_q <= bit_q + 1'b1;
            end
          end else begin
            sub_q <= sub_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign phase   = phase_q;
  assign bit_idx = bit_q;
  assign sub_idx = sub_q;

  // R10
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_tick |=> ($stable(phase_q) && $stable(pil_q) && $stable(bit_q) &&
                    $stable(sub_q) && $stable(word_q)));

  // R5
  burst_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_end && !tx_en_n) |=> (phase_q == PH_PILOT && pil_q == '0));

  // R4
  burst_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_end && tx_en_n) |=> (phase_q == PH_IDLE));

  // R6
  pilot_to_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_tick && phase_q == PH_PILOT && pilot_done) |=> (phase_q == PH_SYNC));

  // R3
  idle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_idle |=> (phase_q == PH_PILOT && pil_q == '0 && word_q == '0));

endmodule

// File: rtl/rc_enc_shaper.sv
module rc_enc_shaper
  import rc_enc_pkg::*;
#(
  parameter int unsigned NBITS = 12,
  parameter int unsigned SPB   = 3,
  localparam int unsigned BW   = (NBITS > 1) ? $clog2(NBITS) : 1,
  localparam int unsigned SW   = (SPB > 1) ? $clog2(SPB) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             word_start,
  input  logic [NBITS-1:0] code_in,
  input  enc_phase_e       phase,
  input  logic [BW-1:0]    bit_idx,
  input  logic [SW-1:0]    sub_idx,
  output logic             level
);

  logic [NBITS-1:0] code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          code_q <= '0;
    else if (word_start) code_q <= code_in;
  end

  always_comb begin
    case (phase)
      PH_SYNC: level = 1'b1;
      PH_DATA: level = slot_level(code_q[bit_idx], int'(sub_idx));
      default: level = 1'b0;
    endcase
  end

  // R9
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !word_start |=> $stable(code_q));

  // R7
  bit_tail_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DATA && sub_idx == SW'(SPB - 1)) |-> !level);

endmodule

// File: rtl/rc_word_encoder.sv
module rc_word_encoder
  import rc_enc_pkg::*;
#(
  parameter int unsigned NBITS = 12,
  parameter int unsigned PILOT = 36,
  parameter int unsigned SPB   = 3,
  parameter int unsigned WORDS = 4,
  localparam int unsigned BW   = (NBITS > 1) ? $clog2(NBITS) : 1,
  localparam int unsigned SW   = (SPB > 1) ? $clog2(SPB) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slot_tick,
  input  logic             tx_en_n,
  input  logic [NBITS-1:0] code_in,
  output logic             ser_out,
  output logic             standby
);

  enc_phase_e    phase;
  logic [BW-1:0] bit_idx;
  logic [SW-1:0] sub_idx;
  logic          word_start;

  rc_enc_seq #(
    .NBITS(NBITS), .PILOT(PILOT), .SPB(SPB), .WORDS(WORDS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick), .tx_en_n(tx_en_n),
    .phase(phase), .bit_idx(bit_idx), .sub_idx(sub_idx),
    .word_start(word_start)
  );

  rc_enc_shaper #(
    .NBITS(NBITS), .SPB(SPB)
  ) u_shape (
    .clk(clk), .rst_n(rst_n), .word_start(word_start), .code_in(code_in),
    .phase(phase), .bit_idx(bit_idx), .sub_idx(sub_idx), .level(ser_out)
  );

  assign standby = (phase == PH_IDLE);

  // R2
  standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> !ser_out);

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_tick |=> $stable(ser_out));

endmodule

// File: tb/sim_rc_word_encoder.sv
module sim_rc_word_encoder;

  localparam int WSLOT = 73;
  localparam int BSLOT = 4 * WSLOT;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slot_tick = 1'b0;
  logic        tx_en_n = 1'b1;
  logic [11:0] code_in = '0;
  wire         ser_out;
  wire         standby;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  rc_word_encoder u0 (
    .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick), .tx_en_n(tx_en_n),
    .code_in(code_in), .ser_out(ser_out), .standby(standby)
  );

  // Stimulus table: code, release tick, expected bursts
  localparam int NCASE = 5;
  localparam logic [11:0] T_CODE [NCASE] = '{12'hC5A, 12'h000, 12'hFFF, 12'h001, 12'h800};
  localparam int          T_REL  [NCASE] = '{1, 100, 292, 293, 700};
  localparam int          T_BUR  [NCASE] = '{1, 1, 1, 2, 3};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One slot tick; sample the slot just entered.
  task automatic tick(output logic lvl, output logic sb, output logic held);
    @(negedge clk) slot_tick = 1'b1;
    @(negedge clk) slot_tick = 1'b0;
    lvl = ser_out;
    sb  = standby;
    @(negedge clk);
    held = (ser_out == lvl);
  endtask

  function automatic logic exp_level(input int s, input logic [11:0] c);
    int b, p;
    if (s < 36) return 1'b0;
    if (s == 36) return 1'b1;
    b = (s - 37) / 3;
    p = (s - 37) % 3;
    return (p == 0) || (p == 1 && !c[b]);
  endfunction

  task automatic run_case(input logic [11:0] ca, input logic [11:0] cb,
                          input int chg, input int rel, input int bursts,
                          input string tag);
    logic lvl, sb, held;
    logic [11:0] cur;
    int mism = 0, holdbad = 0, slots = -1;
    code_in = ca;
    tx_en_n = 1'b0;
    cur = ca;
    for (int i = 0; i < 4000; i++) begin
      if (i == rel) tx_en_n = 1'b1;
      if (i == chg) code_in = cb;
      if (i % WSLOT == 0) cur = code_in;
      tick(lvl, sb, held);
      if (!held) holdbad++;
      if (sb) begin
        slots = i;
        break;
      end
      if (lvl !== exp_level(i % WSLOT, cur)) mism++;
    end
    tx_en_n = 1'b1;
    // R4 R5: slot count equals whole bursts
    chk(slots == bursts * BSLOT, {tag, " R4/R5 slots"}, slots, bursts * BSLOT);
    // R3 R6 R7 R8 R9: decoded stream
    chk(mism == 0, {tag, " R3 R6 R7 R8 R9 stream mismatches"}, mism, 0);
    // R10: no change between ticks
    chk(holdbad == 0, {tag, " R10 change between ticks"}, holdbad, 0);
    // R2: low in standby afterwards
    chk(ser_out == 1'b0, {tag, " R2 output after burst"}, ser_out, 0);
  endtask

  initial begin
    logic lvl, sb, held;
    int bad;
    repeat (3) @(negedge clk);
    // R1
    chk(ser_out == 1'b0, "R1 ser_out in reset", ser_out, 0);
    chk(standby == 1'b1, "R1 standby in reset", standby, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ser_out == 1'b0 && standby == 1'b1, "R1 after reset", {ser_out, standby}, 1);

    // R2: ticks with enable high
    bad = 0;
    code_in = 12'hFFF;
    for (int k = 0; k < 10; k++) begin
      tick(lvl, sb, held);
      if (lvl !== 1'b0 || sb !== 1'b1) bad++;
    end
    chk(bad == 0, "R2 idle with enable high", bad, 0);

    // R3: enable low without ticks
    tx_en_n = 1'b0;
    repeat (6) @(negedge clk);
    chk(standby == 1'b1, "R3 no start without tick", standby, 1);
    tx_en_n = 1'b1;

    for (int c = 0; c < NCASE; c++)
      run_case(T_CODE[c], T_CODE[c], -1, T_REL[c], T_BUR[c], $sformatf("case%0d", c));

    // R9: code changed mid-word reaches only later words
    run_case(12'hA5C, 12'h3C3, 50, 200, 1, "r9_midword");

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #1500000;
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule